// File: doc/BRIEF.md
# Dual-Channel Prescaled PWM Generator

This block produces two pulse-width-modulated outputs that share one timebase. The system clock first passes through an optional divide-by-four stage. The resulting tick drives a reloadable base-period counter, and every base period advances a shared 256-step cycle counter. Each channel compares that step count with its own 8-bit duty setting. The output is high for `duty + 1` steps out of 256, so a channel never reaches 0% and a duty of 255 gives a constant high.

All configuration inputs are held in shadow registers. These are reloaded only while reset is asserted and at the wrap of the 256-step cycle, so a change made mid-cycle cannot produce a runt pulse. Each channel drives a pin through an override mux. When the channel is enabled, the pin carries the waveform with its output enable forced on, whatever the port direction bit says. When the channel is disabled, the pin and its output enable follow the port data and direction inputs directly.

Top module: `dual_pwm_gen`

## Requirements
- R1: One step of the cycle lasts (P+1)·D system clocks, where P is the active base-period setting and D is 4 when `div4_sel` = 1 and 1 when it is 0. After reset is released, the step count equals floor(edges / ((P+1)·D)).
- R2: A base-period setting of 0 is treated as 1, so the step length is never shorter than two ticks.
- R3: The cycle has exactly 256 steps. After step 255 the count wraps to 0 and a new cycle begins.
- R4: While a channel is enabled, its pin is high during steps 0 to `duty` inclusive and low during the rest of the cycle. A duty of 255 is high for the whole cycle, and a duty of 0 is high only during step 0.
- R5: Changes to `duty_a`, `duty_b`, `base_period` and `div4_sel` have no effect until the next cycle wrap, where the values present at that edge are captured.
- R6: The two channels use independent duty settings but share the same step count and cycle timing.
- R7: Each enable input is registered, so it takes effect one clock later. While a channel is enabled, its `oe` output is 1 and its pin shows the waveform, regardless of its direction input.
- R8: While a channel is disabled, its `pin` equals its `dat` input and its `oe` equals its `dir` input, with no clock delay.
- R9: A synchronous reset clears the prescaler, the base-period counter and the step counter, and it clears both registered enables. While reset is asserted, the shadow registers capture the configuration inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div4_sel | input | 1 | 1: tick every 4 clocks; 0: tick every clock |
| base_period | input | 8 | Base-period setting P (0 is treated as 1) |
| duty_a | input | 8 | Channel A duty setting |
| duty_b | input | 8 | Channel B duty setting |
| en_a | input | 1 | Channel A PWM enable |
| en_b | input | 1 | Channel B PWM enable |
| dir_a | input | 1 | Port direction for pin A when channel A is disabled |
| dir_b | input | 1 | Port direction for pin B when channel B is disabled |
| dat_a | input | 1 | Port data for pin A when channel A is disabled |
| dat_b | input | 1 | Port data for pin B when channel B is disabled |
| pin_a | output | 1 | Pin A level |
| oe_a | output | 1 | Pin A output enable |
| pin_b | output | 1 | Pin B level |
| oe_b | output | 1 | Pin B output enable |

## Verification
The step count moves on the same clock edge that ends a step. The pin level therefore changes on edge number (n·(P+1)·D) after reset is released, and the bench samples on the following falling edge. New settings take effect on the first edge after 256·(P+1)·D edges of the current cycle, and the bench's arithmetic model captures its copies of the inputs at exactly that edge count. Enables are seen one edge after they change, while the disabled-path data and direction are seen in the same cycle. The bench steps its model once per rising edge and compares all four outputs at every falling edge, so every one of these delays is checked at its exact cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

   typedef enum logic {
      TICK_EVERY_CLK = 1'b0,
      TICK_PRESCALED = 1'b1
   } tick_sel_e;

   localparam int unsigned PWM_CHANNELS = 2;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
   import pwm_pkg::*;
#(
   parameter int unsigned BP_W    = 8,
   parameter int unsigned PRE_DIV = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  tick_sel_e       sel_act,
   input  logic [BP_W-1:0] bp_act,
   output logic            step
);
   logic            in_tick;
   logic [BP_W-1:0] base_cnt;

   generate
      if (PRE_DIV > 1) begin : g_prediv
         localparam int unsigned PQ_W = $clog2(PRE_DIV);
         localparam logic [PQ_W-1:0] PQ_LAST = PQ_W'(PRE_DIV - 1);
         logic [PQ_W-1:0] pre_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               pre_q <= '0;
            end else if (sel_act == TICK_PRESCALED) begin
               pre_q <= (pre_q == PQ_LAST) ? '0 : pre_q + 1'b1;
            end else begin
               pre_q <= '0;
            end
         end

         assign in_tick = (sel_act == TICK_EVERY_CLK) || (pre_q == PQ_LAST);
      end else begin : g_nodiv
         assign in_tick = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         base_cnt <= '0;
      end else if (in_tick) begin
         base_cnt <= (base_cnt == bp_act) ? '0 : base_cnt + 1'b1;
      end
   end

   assign step = in_tick && (base_cnt == bp_act);

endmodule

// File: rtl/pwm_step_counter.sv
module pwm_step_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] CNT_LAST = '1;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign wrap = step && (cnt == CNT_LAST);

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] duty_in,
   input  logic [CNT_W-1:0] cnt,
   input  logic             en,
   input  logic             dir,
   input  logic             dat,
   output logic             pin,
   output logic             oe,
   output logic             pwm_raw,
   output logic [CNT_W-1:0] duty_sh
);
   logic en_q;

   always_ff @(posedge clk) begin
      if (rst || load) begin
         duty_sh <= duty_in;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q <= 1'b0;
      end else begin
         en_q <= en;
      end
   end

   assign pwm_raw = (cnt <= duty_sh);
   assign pin     = en_q ? pwm_raw : dat;
   assign oe      = en_q | dir;

endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
   import pwm_pkg::*;
#(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned BP_W    = 8,
   parameter int unsigned PRE_DIV = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            div4_sel,
   input  logic [BP_W-1:0] base_period,
   input  logic [CNT_W-1:0] duty_a,
   input  logic [CNT_W-1:0] duty_b,
   input  logic            en_a,
   input  logic            en_b,
   input  logic            dir_a,
   input  logic            dir_b,
   input  logic            dat_a,
   input  logic            dat_b,
   output logic            pin_a,
   output logic            oe_a,
   output logic            pin_b,
   output logic            oe_b
);
   localparam int unsigned NCH = PWM_CHANNELS;
   localparam logic [BP_W-1:0] BP_MIN = BP_W'(1);

   if (CNT_W < 2)  begin : g_bad_cnt  $error("CNT_W must be at least 2"); end
   if (BP_W < 1)   begin : g_bad_bp   $error("BP_W must be at least 1"); end
   if (PRE_DIV < 1) begin : g_bad_div $error("PRE_DIV must be at least 1"); end
   if (PRE_DIV > 1 && (PRE_DIV & (PRE_DIV - 1)) != 0) begin : g_bad_pow
      $error("PRE_DIV must be a power of two");
   end

   tick_sel_e        sel_sh;
   logic [BP_W-1:0]  bp_sh;
   logic             step_w;
   logic             cyc_wrap;
   logic [CNT_W-1:0] step_cnt;

   logic [NCH-1:0]       pwm_w;
   logic [NCH*CNT_W-1:0] duty_sh_w;
   logic [NCH*CNT_W-1:0] duty_in_w;
   logic [NCH-1:0]       en_w, dir_w, dat_w, pin_w, oe_w;

   always_ff @(posedge clk) begin
      if (rst || cyc_wrap) begin
         sel_sh <= div4_sel ? TICK_PRESCALED : TICK_EVERY_CLK;
         bp_sh  <= (base_period == '0) ? BP_MIN : base_period;
      end
   end

   pwm_prescaler #(.BP_W(BP_W), .PRE_DIV(PRE_DIV)) u_pre (
      .clk     (clk),
      .rst     (rst),
      .sel_act (sel_sh),
      .bp_act  (bp_sh),
      .step    (step_w)
   );

   pwm_step_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .step (step_w),
      .cnt  (step_cnt),
      .wrap (cyc_wrap)
   );

   assign duty_in_w = {duty_b, duty_a};
   assign en_w      = {en_b, en_a};
   assign dir_w     = {dir_b, dir_a};
   assign dat_w     = {dat_b, dat_a};

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      pwm_channel #(.CNT_W(CNT_W)) u_ch (
         .clk     (clk),
         .rst     (rst),
         .load    (cyc_wrap),
         .duty_in (duty_in_w[c*CNT_W +: CNT_W]),
         .cnt     (step_cnt),
         .en      (en_w[c]),
         .dir     (dir_w[c]),
         .dat     (dat_w[c]),
         .pin     (pin_w[c]),
         .oe      (oe_w[c]),
         .pwm_raw (pwm_w[c]),
         .duty_sh (duty_sh_w[c*CNT_W +: CNT_W])
      );
   end

   assign pin_a = pin_w[0];
   assign oe_a  = oe_w[0];
   assign pin_b = pin_w[1];
   assign oe_b  = oe_w[1];

endmodule

// File: rtl/pwm_gen_checks.sv
module pwm_gen_checks #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             step,
   input logic             wrap,
   input logic [CNT_W-1:0] cnt,
   input logic [1:0]       pwm_w,
   input logic [2*CNT_W-1:0] duty_sh_w,
   input logic             en_a,
   input logic             dir_a,
   input logic             dat_a,
   input logic             pin_a,
   input logic             oe_a
);
   localparam logic [CNT_W-1:0] LAST = '1;

   p_hold_r1: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(cnt));

   p_advance_r1: assert property (@(posedge clk) disable iff (rst)
      (step && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

   p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
      wrap |=> (cnt == '0));

   p_full_duty_r4: assert property (@(posedge clk) disable iff (rst)
      (duty_sh_w[CNT_W-1:0] == LAST) |-> pwm_w[0]);

   p_step0_high_r4: assert property (@(posedge clk) disable iff (rst)
      (cnt == '0) |-> (pwm_w == 2'b11));

   p_duty_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !wrap |=> $stable(duty_sh_w));

   p_override_r7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(en_a)) |-> (oe_a && pin_a == pwm_w[0]));

   p_passthru_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(en_a)) |-> (pin_a == dat_a && oe_a == dir_a));

   p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (cnt == '0));

endmodule

bind dual_pwm_gen pwm_gen_checks #(.CNT_W(CNT_W)) u_checks (
   .clk       (clk),
   .rst       (rst),
   .step      (step_w),
   .wrap      (cyc_wrap),
   .cnt       (step_cnt),
   .pwm_w     (pwm_w),
   .duty_sh_w (duty_sh_w),
   .en_a      (en_a),
   .dir_a     (dir_a),
   .dat_a     (dat_a),
   .pin_a     (pin_a),
   .oe_a      (oe_a)
);

// File: tb/dual_pwm_gen_test.sv
module dual_pwm_gen_test;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst, div4_sel;
   logic [7:0] base_period, duty_a, duty_b;
   logic       en_a, en_b, dir_a, dir_b, dat_a, dat_b;
   logic       pin_a, oe_a, pin_b, oe_b;

   dual_pwm_gen uut (
      .clk(clk), .rst(rst), .div4_sel(div4_sel), .base_period(base_period),
      .duty_a(duty_a), .duty_b(duty_b), .en_a(en_a), .en_b(en_b),
      .dir_a(dir_a), .dir_b(dir_b), .dat_a(dat_a), .dat_b(dat_b),
      .pin_a(pin_a), .oe_a(oe_a), .pin_b(pin_b), .oe_b(oe_b)
   );

   int checks = 0;
   int errors = 0;
   int k = 0;
   int per = 2;
   int dsh0 = 0;
   int dsh1 = 0;
   bit enq0 = 0;
   bit enq1 = 0;
   bit rst_seen = 0;

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d (edge %0d of cycle)", tag, what, act, exp, k);
      end
   endtask

   // Captured copy of the configuration, taken at reset and at each cycle wrap (R5)
   task automatic latch_cfg();
      int b;
      b = (base_period == 8'd0) ? 1 : int'(base_period);
      per  = (b + 1) * (div4_sel ? 4 : 1);
      dsh0 = int'(duty_a);
      dsh1 = int'(duty_b);
   endtask

   task automatic tick(string tag);
      int  st;
      bit  p0, p1;
      @(posedge clk);
      rst_seen = rst;
      if (rst) begin
         k = 0; enq0 = 0; enq1 = 0;
         latch_cfg();
      end else begin
         k++;
         if (k == 256 * per) begin
            k = 0;
            latch_cfg();
         end
         enq0 = en_a;
         enq1 = en_b;
      end
      @(negedge clk);
      st = k / per;
      p0 = (st <= dsh0);
      p1 = (st <= dsh1);
      if (enq0) begin
         chk(tag,  "pin_a", int'(pin_a), int'(p0));
         chk("R7", "oe_a",  int'(oe_a), 1);
      end else begin
         chk(rst_seen ? "R9" : "R8", "pin_a", int'(pin_a), int'(dat_a));
         chk(rst_seen ? "R9" : "R8", "oe_a",  int'(oe_a),  int'(dir_a));
      end
      if (enq1) begin
         chk(tag,  "pin_b", int'(pin_b), int'(p1));
         chk("R7", "oe_b",  int'(oe_b), 1);
      end else begin
         chk(rst_seen ? "R9" : "R8", "pin_b", int'(pin_b), int'(dat_b));
         chk(rst_seen ? "R9" : "R8", "oe_b",  int'(oe_b),  int'(dir_b));
      end
   endtask

   task automatic run(int n, string tag);
      for (int i = 0; i < n; i++) tick(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; div4_sel = 1'b0; base_period = 8'd1;
      duty_a = 8'd0; duty_b = 8'd255;
      en_a = 1'b1; en_b = 1'b1; dir_a = 1'b0; dir_b = 1'b1;
      dat_a = 1'b1; dat_b = 1'b0;
      // R9: enables held off during reset, pins follow the port path
      run(3, "R9");
      rst = 1'b0;
      // R4: duty 0 high only in step 0, duty 255 always high
      run(300, "R4");
      // R5: new settings mid-cycle wait for the wrap; R2: base period 0 acts as 1
      div4_sel = 1'b1; base_period = 8'd0; duty_a = 8'd127; duty_b = 8'd3;
      run(400, "R5");
      run(2000, "R2");
      // R1: step length with another base period, divide-by-one tick
      div4_sel = 1'b0; base_period = 8'd3; duty_a = 8'd200; duty_b = 8'd50;
      run(2500, "R1");
      // R6: independent duties over several cycles
      for (int i = 0; i < 6; i++) begin
         duty_a = 8'((i * 53) % 256);
         duty_b = 8'(255 - (i * 29) % 256);
         run(1024, "R6");
      end
      // R3: full cycle wrap with a fast step
      base_period = 8'd1; duty_a = 8'd0; duty_b = 8'd254;
      run(1500, "R3");
      // R7 and R8: enable override versus port pass-through
      for (int i = 0; i < 40; i++) begin
         en_a  = (i % 3) != 0;
         en_b  = (i % 4) == 1;
         dir_a = i[0];
         dir_b = ~i[1];
         dat_a = i[1];
         dat_b = i[0];
         run(37, "R7");
      end
      en_a = 1'b1; en_b = 1'b1;
      run(5, "R7");
      // R9: reset mid-cycle clears counters and reloads settings at once
      rst = 1'b1; duty_a = 8'd10; duty_b = 8'd100; base_period = 8'd2;
      run(2, "R9");
      rst = 1'b0;
      run(800, "R9");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule